// File: doc/BRIEF.md
# Memory Channel Request Packet Receiver

This block sits behind the receive side of a 9-bit double-data-rate memory channel. Every clock it is handed two 9-bit symbols (the even and the odd slot of that cycle) and the two matching samples of a framing control line. When the framing line is high in an even slot while the block is idle, a request packet starts. The block then gathers that cycle and the next two, six symbol slots in all. From them it assembles a 36-bit address, an 8-bit byte count and a 6-bit command made of a 4-bit major code and a 2-bit extension.

The command is decoded into a one-hot operation class plus a 2-bit mask qualifier. An unknown command, or a packet whose reserved slot is not all zero, raises an illegal flag instead of a class. Address, count, class, qualifier and illegal flag are presented together with a packet-valid strobe for exactly one clock; at every other time all of these outputs read zero.

The control is a three-state machine. ST_IDLE waits for Start; ST_IDLE goes to ST_MID when the even framing sample is high, and otherwise stays. ST_MID holds the second cycle and always goes to ST_TAIL. ST_TAIL takes the third cycle live, loads the output register and always goes back to ST_IDLE, so a new Start can be taken in the very cycle the strobe is high.

Top module: `rpkt_rx`

## Requirements
- R1: While reset is asserted and after its release, before any packet, pkt_valid, pkt_addr, pkt_count, pkt_class, pkt_mask and pkt_illegal are all zero.
- R2: A packet begins only when ctl_even is 1 in a cycle where the block is idle; ctl_odd alone, and symbols without ctl_even, start nothing.
- R3: With slot n meaning symbol n of the packet (cycle n/2, even when n is even), the address is {slot3, slot2, slot1, slot0}, slot0 holding address bits 8:0.
- R4: The count is slot4 bits 7:0; the command extension is {ctl of slot5, slot4 bit 8}; the major code bits 0..3 are the framing samples of slots 1..4 in that order.
- R5: If Start is sampled at clock edge k, pkt_valid is 1 during the cycle after edge k+2 and for that one cycle only.
- R6: A framing sample that is high during the second or third cycle of a packet is taken as a command bit and does not begin a new packet.
- R7: Start may be given in the cycle directly after the third cycle of a packet, so packets can follow with no gap.
- R8: Major/extension codes decode to one-hot pkt_class: 0000/00 bit 0 (sequential read), 0000/01 bit 1 (random read), 0110/00 bit 2 (register read), 0111/00 bit 3 (register write), 1111/00 bit 4 (broadcast register write), with pkt_mask zero.
- R9: Major code 0100 with any extension gives bit 5 (sequential write), 1000 with any extension gives bit 6 (random write), 1100 with extension 00, 01 or 11 gives bit 7 (byte-masked random write); pkt_mask then equals the extension: 00 no mask, 01 static mask, 10 dynamic mask with packet data, 11 static data with dynamic mask.
- R10: Any other major/extension combination sets pkt_illegal with pkt_class and pkt_mask zero, while address and count are still presented.
- R11: A nonzero slot5 sets pkt_illegal with pkt_class and pkt_mask zero, whatever the command.
- R12: pkt_class is never more than one-hot, and outside the pkt_valid cycle all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one even and one odd slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_even | input | 9 | Symbol of the even slot of this cycle |
| sym_odd | input | 9 | Symbol of the odd slot of this cycle |
| ctl_even | input | 1 | Framing line sample in the even slot |
| ctl_odd | input | 1 | Framing line sample in the odd slot |
| pkt_valid | output | 1 | One-cycle strobe: packet fields below are valid |
| pkt_addr | output | 36 | Assembled address |
| pkt_count | output | 8 | Byte count |
| pkt_class | output | 8 | One-hot operation class |
| pkt_mask | output | 2 | Write mask qualifier |
| pkt_illegal | output | 1 | Unknown command or nonzero reserved slot |

## Verification
The bench builds the block with its default widths: 9-bit symbols and three cycles per packet, which is the only geometry the field layout defines. At these values every one of the 64 command codes is within reach, and the bench walks all the listed legal codes and several unlisted ones, including packets whose command bits place a high framing sample in the second and third cycle. Packets are sent back to back, with idle gaps, with odd-slot framing noise while idle and with a nonzero reserved slot, so each state transition of the machine is crossed under data that differs from the previous packet.

// File: rtl/rpkt_pkg.sv
package rpkt_pkg;

    localparam int SYM_W   = 9;
    localparam int NCYC    = 3;
    localparam int NSLOT   = 2 * NCYC;
    localparam int ADDR_W  = 4 * SYM_W;
    localparam int CNT_W   = 8;
    localparam int OP_W    = 4;
    localparam int OPX_W   = 2;
    localparam int NCLS    = 8;
    localparam int CTL_W   = NSLOT - 1;

    // one-hot class bit positions
    localparam int CLS_RD_SEQ  = 0;
    localparam int CLS_RD_RND  = 1;
    localparam int CLS_REG_RD  = 2;
    localparam int CLS_REG_WR  = 3;
    localparam int CLS_REG_BC  = 4;
    localparam int CLS_WR_SEQ  = 5;
    localparam int CLS_WR_RND  = 6;
    localparam int CLS_WR_BYTE = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MID  = 2'd1,
        ST_TAIL = 2'd2
    } rx_state_t;

endpackage

// File: rtl/rpkt_collector.sv
module rpkt_collector
    import rpkt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SYM_W-1:0]       sym_even,
    input  logic [SYM_W-1:0]       sym_odd,
    input  logic                   ctl_even,
    input  logic                   ctl_odd,
    output logic                   fire,
    output logic [NSLOT*SYM_W-1:0] slot_bus,
    output logic [CTL_W-1:0]       ctl_bus
);

    localparam int HOLD_N = NCYC - 1;

    rx_state_t state, state_nx;
    logic      start_take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx   = state;
        start_take = 1'b0;
        fire       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                start_take = ctl_even;
                if (ctl_even) state_nx = ST_MID;
            end
            ST_MID:  state_nx = ST_TAIL;
            ST_TAIL: begin
                fire     = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // holding stages for the cycles before the last one
    for (genvar gi = 0; gi < HOLD_N; gi++) begin : g_hold
        logic             take;
        logic [SYM_W-1:0] se, so;
        logic             ce, co;
        if (gi == 0) begin : g_first
            assign take = start_take;
        end else begin : g_next
            assign take = (state == ST_MID);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                se <= '0;
                so <= '0;
                ce <= 1'b0;
                co <= 1'b0;
            end else if (take) begin
                se <= sym_even;
                so <= sym_odd;
                ce <= ctl_even;
                co <= ctl_odd;
            end
        end
    end

    assign slot_bus = {sym_odd, sym_even,
                       g_hold[1].so, g_hold[1].se,
                       g_hold[0].so, g_hold[0].se};
    assign ctl_bus  = {ctl_odd, ctl_even,
                       g_hold[1].co, g_hold[1].ce,
                       g_hold[0].co};

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ctl_even) |=> (state == ST_MID)); // R2
    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MID) |-> g_hold[0].ce); // R2
    AST_MID_TO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MID) |=> (state == ST_TAIL)); // R6
    AST_TAIL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |=> (state == ST_IDLE)); // R5

endmodule

// File: rtl/rpkt_cmd_decode.sv
module rpkt_cmd_decode
    import rpkt_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [OPX_W-1:0] opx,
    input  logic             rsv_clear,
    output logic [NCLS-1:0]  cls,
    output logic [OPX_W-1:0] mask,
    output logic             illegal
);

    logic [NCLS-1:0]  raw_cls;
    logic [OPX_W-1:0] raw_mask;

    always_comb begin
        raw_cls  = '0;
        raw_mask = '0;
        unique case ({op, opx})
            6'b0000_00: raw_cls[CLS_RD_SEQ] = 1'b1;
            6'b0000_01: raw_cls[CLS_RD_RND] = 1'b1;
            6'b0110_00: raw_cls[CLS_REG_RD] = 1'b1;
            6'b0111_00: raw_cls[CLS_REG_WR] = 1'b1;
            6'b1111_00: raw_cls[CLS_REG_BC] = 1'b1;
            6'b0100_00, 6'b0100_01, 6'b0100_10, 6'b0100_11: begin
                raw_cls[CLS_WR_SEQ] = 1'b1;
                raw_mask            = opx;
            end
            6'b1000_00, 6'b1000_01, 6'b1000_10, 6'b1000_11: begin
                raw_cls[CLS_WR_RND] = 1'b1;
                raw_mask            = opx;
            end
            6'b1100_00, 6'b1100_01, 6'b1100_11: begin
                raw_cls[CLS_WR_BYTE] = 1'b1;
                raw_mask             = opx;
            end
            default: raw_cls = '0;
        endcase
    end

    assign illegal = (raw_cls == '0) || !rsv_clear;
    assign cls     = illegal ? '0 : raw_cls;
    assign mask    = illegal ? '0 : raw_mask;

endmodule

// File: rtl/rpkt_rx.sv
module rpkt_rx
    import rpkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYM_W-1:0]  sym_even,
    input  logic [SYM_W-1:0]  sym_odd,
    input  logic              ctl_even,
    input  logic              ctl_odd,
    output logic              pkt_valid,
    output logic [ADDR_W-1:0] pkt_addr,
    output logic [CNT_W-1:0]  pkt_count,
    output logic [NCLS-1:0]   pkt_class,
    output logic [OPX_W-1:0]  pkt_mask,
    output logic              pkt_illegal
);

    logic                   fire;
    logic [NSLOT*SYM_W-1:0] slot_bus;
    logic [CTL_W-1:0]       ctl_bus;
    logic [SYM_W-1:0]       slot [NSLOT];
    logic [NCLS-1:0]        dec_cls;
    logic [OPX_W-1:0]       dec_mask;
    logic                   dec_illegal;

    rpkt_collector u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_even (sym_even),
        .sym_odd  (sym_odd),
        .ctl_even (ctl_even),
        .ctl_odd  (ctl_odd),
        .fire     (fire),
        .slot_bus (slot_bus),
        .ctl_bus  (ctl_bus)
    );

    for (genvar gs = 0; gs < NSLOT; gs++) begin : g_slot
        assign slot[gs] = slot_bus[gs*SYM_W +: SYM_W];
    end

    rpkt_cmd_decode u_dec (
        .op        (ctl_bus[OP_W-1:0]),
        .opx       ({ctl_bus[OP_W], slot[4][CNT_W]}),
        .rsv_clear (slot[5] == '0),
        .cls       (dec_cls),
        .mask      (dec_mask),
        .illegal   (dec_illegal)
    );

    // output register: all fields zero except in the strobe cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_valid   <= 1'b0;
            pkt_addr    <= '0;
            pkt_count   <= '0;
            pkt_class   <= '0;
            pkt_mask    <= '0;
            pkt_illegal <= 1'b0;
        end else if (fire) begin
            pkt_valid   <= 1'b1;
            pkt_addr    <= {slot[3], slot[2], slot[1], slot[0]};
            pkt_count   <= slot[4][CNT_W-1:0];
            pkt_class   <= dec_cls;
            pkt_mask    <= dec_mask;
            pkt_illegal <= dec_illegal;
        end else begin
            pkt_valid   <= 1'b0;
            pkt_addr    <= '0;
            pkt_count   <= '0;
            pkt_class   <= '0;
            pkt_mask    <= '0;
            pkt_illegal <= 1'b0;
        end
    end

    AST_FIRE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pkt_valid); // R5
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid); // R5
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pkt_class)); // R12
    AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> (pkt_class == '0 && !pkt_illegal && pkt_count == '0 && pkt_addr == '0)); // R12
    AST_ILLEGAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_illegal |-> (pkt_class == '0 && pkt_mask == '0 && pkt_valid)); // R10
    AST_LEGAL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_illegal) |-> ($countones(pkt_class) == 1)); // R8

endmodule

// File: tb/test_rpkt_rx.sv
module test_rpkt_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  sym_even = '0, sym_odd = '0;
    logic        ctl_even = 1'b0, ctl_odd = 1'b0;
    logic        pkt_valid, pkt_illegal;
    logic [35:0] pkt_addr;
    logic [7:0]  pkt_count, pkt_class;
    logic [1:0]  pkt_mask;

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    rpkt_rx i_rpkt_rx (
        .clk(clk), .rst_n(rst_n),
        .sym_even(sym_even), .sym_odd(sym_odd),
        .ctl_even(ctl_even), .ctl_odd(ctl_odd),
        .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_count(pkt_count),
        .pkt_class(pkt_class), .pkt_mask(pkt_mask), .pkt_illegal(pkt_illegal)
    );

    // expected decode: {illegal, mask[1:0], class[7:0]}
    function automatic logic [10:0] ref_decode(input logic [5:0] code, input logic [8:0] rsv);
        logic [7:0] c = '0;
        logic [1:0] m = '0;
        if      (code == 6'b000000) c = 8'd1;
        else if (code == 6'b000001) c = 8'd2;
        else if (code == 6'b011000) c = 8'd4;
        else if (code == 6'b011100) c = 8'd8;
        else if (code == 6'b111100) c = 8'd16;
        else if (code[5:2] == 4'b0100) begin c = 8'd32; m = code[1:0]; end
        else if (code[5:2] == 4'b1000) begin c = 8'd64; m = code[1:0]; end
        else if (code[5:2] == 4'b1100 && code[1:0] != 2'b10) begin c = 8'd128; m = code[1:0]; end
        if (c == 0 || rsv != 0) return {1'b1, 2'b00, 8'd0};
        return {1'b0, m, c};
    endfunction

    // behavioural reference: integer phase and a queue of captured symbols
    int          mphase = 0;
    logic [8:0]  sq[$];
    logic        cq[$];
    logic        e_valid = 0, e_ill = 0;
    logic [35:0] e_addr = 0;
    logic [7:0]  e_cnt = 0, e_cls = 0;
    logic [1:0]  e_mask = 0;

    always @(posedge clk or negedge rst_n) begin
        logic [10:0] d;
        e_valid = 0; e_addr = 0; e_cnt = 0; e_cls = 0; e_mask = 0; e_ill = 0;
        if (!rst_n) begin
            mphase = 0; sq.delete(); cq.delete();
        end else if (mphase == 0) begin
            if (ctl_even) begin
                sq.delete(); cq.delete();
                sq.push_back(sym_even); sq.push_back(sym_odd);
                cq.push_back(ctl_even); cq.push_back(ctl_odd);
                mphase = 1;
            end
        end else begin
            sq.push_back(sym_even); sq.push_back(sym_odd);
            cq.push_back(ctl_even); cq.push_back(ctl_odd);
            mphase = mphase + 1;
            if (mphase == 3) begin
                d = ref_decode({cq[4], cq[3], cq[2], cq[1], cq[5], sq[4][8]}, sq[5]);
                e_valid = 1;
                e_addr  = {sq[3], sq[2], sq[1], sq[0]};
                e_cnt   = sq[4][7:0];
                {e_ill, e_mask, e_cls} = d;
                mphase = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if ({pkt_valid, pkt_addr, pkt_count, pkt_class, pkt_mask, pkt_illegal} !==
                {e_valid, e_addr, e_cnt, e_cls, e_mask, e_ill}) begin
                errors++;
                $display("FAIL %s: got v=%0b a=%h n=%h c=%b m=%b i=%0b exp v=%0b a=%h n=%h c=%b m=%b i=%0b",
                         cur_req, pkt_valid, pkt_addr, pkt_count, pkt_class, pkt_mask, pkt_illegal,
                         e_valid, e_addr, e_cnt, e_cls, e_mask, e_ill);
            end
        end
    end

    task automatic drive(input logic [8:0] se, input logic [8:0] so, input logic ce, input logic co);
        @(negedge clk);
        #1;
        sym_even = se; sym_odd = so; ctl_even = ce; ctl_odd = co;
    endtask

    task automatic send(input logic [35:0] a, input logic [7:0] n,
                        input logic [3:0] op, input logic [1:0] opx, input logic [8:0] rsv);
        drive(a[8:0],   a[17:9],  1'b1,  op[0]);
        drive(a[26:18], a[35:27], op[1], op[2]);
        drive({opx[0], n}, rsv,   op[3], opx[1]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, '0, 1'b0, 1'b0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang exp completion");
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        idle(3);

        cur_req = "R2";  // odd framing and data noise while idle
        drive(9'h1FF, 9'h155, 1'b0, 1'b1);
        drive(9'h0AA, 9'h1FF, 1'b0, 1'b1);
        idle(2);

        cur_req = "R3 R4 R8 R5";
        send(36'hF_FFFF_FFFF, 8'hFF, 4'b0000, 2'b00, '0);
        idle(2);
        send(36'hA_5A5A_5A5A, 8'h3C, 4'b0000, 2'b01, '0);
        idle(1);
        send(36'h1_2345_6789, 8'h01, 4'b0111, 2'b00, '0);
        send(36'h8_0000_0001, 8'h80, 4'b1111, 2'b00, '0);

        cur_req = "R6 R8";  // high framing in later cycles
        send(36'h0_0000_0200, 8'h10, 4'b0110, 2'b00, '0);

        cur_req = "R7 R9";  // writes, back to back
        for (int x = 0; x < 4; x++) send(36'h3_0000_0000 + 36'(x), 8'(x * 17), 4'b0100, 2'(x), '0);
        for (int x = 0; x < 4; x++) send(36'h0_F0F0_F0F0 ^ 36'(x), 8'(255 - x), 4'b1000, 2'(x), '0);
        send(36'h5_5555_5555, 8'h55, 4'b1100, 2'b00, '0);
        send(36'h6_6666_6666, 8'h66, 4'b1100, 2'b01, '0);
        send(36'h7_7777_7777, 8'h77, 4'b1100, 2'b11, '0);
        idle(2);

        cur_req = "R10";
        send(36'h9_9999_9999, 8'h99, 4'b1100, 2'b10, '0);
        send(36'h0_0000_0123, 8'h42, 4'b0001, 2'b00, '0);
        send(36'h0_0000_0456, 8'h24, 4'b1111, 2'b01, '0);
        send(36'h0_0000_0789, 8'h18, 4'b0000, 2'b10, '0);
        send(36'h0_0000_0abc, 8'h81, 4'b0110, 2'b11, '0);
        idle(1);

        cur_req = "R11";
        send(36'h2_0000_0002, 8'h20, 4'b0000, 2'b00, 9'h100);
        send(36'h2_0000_0003, 8'h21, 4'b0100, 2'b10, 9'h001);
        idle(1);

        cur_req = "R12 R5";
        send(36'hC_3C3C_3C3C, 8'hC3, 4'b1000, 2'b10, '0);
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule